// File: doc/BRIEF.md
# Serial Programming Table-Read Target

This block is the target end of a two-wire serial programming link. The host drives a serial clock and one data line that can change direction. Every transfer is a frame of 20 serial clocks. The first 4 clocks carry a command code. The other 16 carry an operand phase. Two commands are understood. A core-instruction command delivers a 16-bit instruction word, and only the handful of words that load a literal and copy it into one byte of a 22-bit table pointer take effect. A table-read command fetches the byte at the pointer from a synchronous memory and returns it on the data line. The pointer then advances by one.

In a table-read frame, the data line stays an input for the first 8 operand clocks while the memory is read. The target then takes the line, drives the byte out over the last 8 operand clocks, and releases the line when the frame ends. The host is expected to hold the clock low across the turnaround. The serial clock is the register clock of the block, and a synchronous reset returns it to the start of a command fetch.

Top module: `sprog_tblrd_target`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the table pointer and the working register to zero, deasserts `sd_oe` and makes the next rising edge the first bit of a new command, even when reset arrives in the middle of a frame.
- R2: A frame is 20 rising edges of `clk`. `sd_in` is sampled on each edge: 4 command bits first, then 16 operand bits, each field least significant bit first.
- R3: In a core-instruction frame (command code 4'b0000), an operand word 16'h0Exx copies xx into the working register. When several such words arrive, the most recent one is the value that takes effect.
- R4: Core operand words 16'h6EF8, 16'h6EF7 and 16'h6EF6 copy the working register into pointer bits [21:16] (from working-register bits [5:0]), [15:8] and [7:0] respectively. The pointer is visible on `mem_addr` from the edge that ends the frame.
- R5: Any other core operand word changes neither the pointer nor the working register.
- R6: In a table-read frame (command code 4'b1001), the byte that the memory returns for the address on `mem_addr` comes out on `sd_out`, with bit k present during operand clock 9+k (k = 0 to 7). `mem_rdata` is registered in the memory one clock after the address.
- R7: `sd_oe` is high only during operand clocks 9 to 16 of a table-read frame, and it is low for every other clock.
- R8: A table read adds one to the pointer after the byte is captured. The carry ripples across all 22 bits, and 3FFFFFh wraps to 000000h. Back-to-back reads therefore return consecutive bytes.
- R9: A frame whose command code is neither 4'b0000 nor 4'b1001 leaves the pointer unchanged and keeps `sd_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial programming clock; rising edge samples `sd_in` |
| rst | input | 1 | Synchronous reset, active high |
| sd_in | input | 1 | Serial data from the host |
| sd_out | output | 1 | Serial data to the host, valid while `sd_oe` is high |
| sd_oe | output | 1 | Data-line output enable |
| mem_addr | output | PTR_W | Table pointer, used as the memory read address |
| mem_rdata | input | 8 | Byte from the synchronous memory, one clock after the address |

## Verification
The bench builds the block with the default 22-bit pointer. At this width the 3FFFFFh wrap, the six-bit upper-byte mask and the carries out of the low and middle bytes can all be reached with a single pointer load each. The stimulus vectors place the pointer on each of these boundaries. Every read is followed by a second read, so the post-increment is seen both on `mem_addr` and in the returned data. The bench memory returns a byte pattern computed from the address.

// File: rtl/sprog_tblrd_target.sv
module sprog_tblrd_target #(
  parameter int PTR_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sd_in,
  output logic             sd_out,
  output logic             sd_oe,
  output logic [PTR_W-1:0] mem_addr,
  input  logic [7:0]       mem_rdata
);
  localparam int CMD_W = 4;
  localparam int OPR_W = 16;
  localparam int FRAME = CMD_W + OPR_W;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] C_TURN = CNT_W'(CMD_W + OPR_W / 2 - 1);
  localparam logic [CNT_W-1:0] C_OPR  = CNT_W'(CMD_W);
  localparam logic [CMD_W-1:0] CMD_CORE  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_TBLRD = 4'b1001;

  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd;
  logic [OPR_W-1:0] opr;
  logic [7:0]       wreg;
  logic [7:0]       dout;
  logic [PTR_W-1:0] ptr;

  wire             last   = (cnt == C_LAST);
  wire             is_rd  = (cmd == CMD_TBLRD);
  wire             capt   = is_rd && (cnt == C_TURN);
  wire [OPR_W-1:0] insn   = {sd_in, opr[OPR_W-1:1]};
  wire             do_ins = (cmd == CMD_CORE) && last;

  assign sd_oe    = is_rd && (cnt > C_TURN);
  assign sd_out   = sd_oe & dout[0];
  assign mem_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
      opr <= '0;
    end else if (cnt < C_OPR) begin
      cmd <= {sd_in, cmd[CMD_W-1:1]};
    end else begin
      opr <= insn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      wreg <= '0;
      dout <= '0;
    end else begin
      if (capt) begin
        dout <= mem_rdata;
        ptr  <= ptr + 1'b1;
      end else if (sd_oe) begin
        dout <= {1'b0, dout[7:1]};
      end
      if (do_ins) begin
        if (insn[15:8] == 8'h0E) wreg <= insn[7:0];
        else if (insn == 16'h6EF8) ptr[PTR_W-1:16] <= wreg[PTR_W-17:0];
        else if (insn == 16'h6EF7) ptr[15:8] <= wreg;
        else if (insn == 16'h6EF6) ptr[7:0] <= wreg;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!sd_oe && mem_addr == '0));
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    last |=> (cnt == '0));
  a_r7_oe_closed: assert property (@(posedge clk) disable iff (rst)
    (cnt <= C_TURN) |-> !sd_oe);
  a_r7_oe_run: assert property (@(posedge clk) disable iff (rst)
    (sd_oe && !last) |=> sd_oe);
  a_r7_oe_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_oe) |-> ($past(cnt) == C_TURN));
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
    capt |=> (mem_addr == PTR_W'($past(mem_addr) + 1'b1)));
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!capt && !do_ins) |=> $stable(mem_addr));
endmodule

// File: tb/tb_sprog_tblrd_target.sv
module tb_sprog_tblrd_target;
  localparam int PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h000000, 24'hFFFFFF, 24'h0000FF, 24'h00FFFF, 24'h123456, 24'h2ABCDE
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_in = 1'b0;
  logic sd_out, sd_oe;
  logic [21:0] mem_addr;
  logic [7:0] mem_rdata;
  int checks = 0;
  int failures = 0;

  always #(PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) mem_rdata <= pat(mem_addr);

  sprog_tblrd_target dut (
    .clk(clk), .rst(rst), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [3:0] c, input logic [15:0] w, input bit rd,
                       output logic [7:0] b, output bit oe_err);
    b = '0;
    oe_err = 0;
    for (int i = 0; i < 20; i++) begin
      if (i >= 12 && rd) begin
        b[i-12] = sd_out;
        if (!sd_oe) oe_err = 1;
      end else if (sd_oe) begin
        oe_err = 1;
      end
      sd_in = (i < 4) ? c[i] : w[i-4];
      @(negedge clk);
    end
    if (sd_oe) oe_err = 1;
  endtask

  task automatic core(input logic [15:0] w);
    logic [7:0] b;
    bit e;
    frame(4'b0000, w, 1'b0, b, e);
  endtask

  task automatic rd(output logic [7:0] b, output bit e);
    frame(4'b1001, 16'h0000, 1'b1, b, e);
  endtask

  task automatic set_ptr(input logic [23:0] v);
    core({8'h0E, v[23:16]}); core(16'h6EF8);
    core({8'h0E, v[15:8]});  core(16'h6EF7);
    core({8'h0E, v[7:0]});   core(16'h6EF6);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b;
    bit e;
    logic [21:0] a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(mem_addr == 22'h0 && !sd_oe, "R1 reset state", {9'b0, sd_oe, mem_addr}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      a = {VEC[v][21:16], VEC[v][15:0]};
      set_ptr(VEC[v]);
      chk(mem_addr == a, "R4 pointer load", {10'b0, mem_addr}, {10'b0, a});
      rd(b, e);
      chk(b == pat(a), "R6 read byte", {24'b0, b}, {24'b0, pat(a)});
      chk(!e, "R7 oe window", {31'b0, e}, 32'h0);
      chk(mem_addr == a + 1'b1, "R8 post increment", {10'b0, mem_addr}, {10'b0, 22'(a + 1'b1)});
      rd(b, e);
      chk(b == pat(a + 1'b1), "R8 consecutive byte", {24'b0, b}, {24'b0, pat(a + 1'b1)});
    end

    // R3 and R2: latest literal wins, LSB-first decode
    set_ptr(24'h0A0B0C);
    core(16'h0E11); core(16'h0E22); core(16'h6EF6);
    chk(mem_addr == 22'h0A0B22, "R3 latest literal", {10'b0, mem_addr}, 32'h0A0B22);
    core(16'h0E3C); core(16'h6EF7);
    chk(mem_addr == 22'h0A3C22, "R2 operand bit order", {10'b0, mem_addr}, 32'h0A3C22);

    // R5: unrecognised instructions
    core(16'h0E77); core(16'hABCD); core(16'h6EF9); core(16'h70EE);
    chk(mem_addr == 22'h0A3C22, "R5 pointer untouched", {10'b0, mem_addr}, 32'h0A3C22);
    core(16'h6EF6);
    chk(mem_addr == 22'h0A3C77, "R5 working reg kept", {10'b0, mem_addr}, 32'h0A3C77);

    // R9: unknown command codes
    frame(4'b0101, 16'h6EF6, 1'b0, b, e);
    chk(!e, "R9 oe stays low 0101", {31'b0, e}, 32'h0);
    frame(4'b1000, 16'h0000, 1'b0, b, e);
    chk(!e, "R9 oe stays low 1000", {31'b0, e}, 32'h0);
    chk(mem_addr == 22'h0A3C77, "R9 pointer unchanged", {10'b0, mem_addr}, 32'h0A3C77);

    // R1: reset mid-frame
    sd_in = 1'b1; @(negedge clk);
    sd_in = 1'b0; @(negedge clk);
    rst = 1'b1; @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk(mem_addr == 22'h0 && !sd_oe, "R1 mid-frame reset", {9'b0, sd_oe, mem_addr}, 32'h0);
    core(16'h6EF6);
    chk(mem_addr == 22'h0, "R1 working reg cleared", {10'b0, mem_addr}, 32'h0);
    set_ptr(24'h01FF00);
    rd(b, e);
    chk(b == pat(22'h01FF00) && !e, "R1 realigned read", {23'b0, e, b}, {24'b0, pat(22'h01FF00)});

    summary();
    $finish;
  end
endmodule